// File: doc/BRIEF.md
# Palette DAC Host Register and Colour Lookup Logic

This block holds the host-side registers and the colour lookup table of an 8-bit palette DAC. A host reaches it through one shared address register. After loading that register, the host either reads or writes a control register whose number is the address value, or streams colour-map bytes through a data port. Each colour-map entry is three bytes, red then green then blue. A hidden component counter steps through the three bytes and then moves the pointer to the next entry. Any run of transfers therefore covers consecutive entries in order, and 768 transfers after writing address 0 cover the whole table.

The host bus is 32 bits wide, but only one byte lane carries data. A write is taken from the lane chosen by a parameter, so a host that copies its byte into every lane works without change. Reads return the byte copied into all lanes. The pixel side applies the read mask to an incoming index. While the blink phase input is high, it also clears the bits selected by the blink mask. The masked index then selects an entry, which is presented as 24-bit RGB one clock later, or as black when the command register has the palette disabled.

Top module: `pdac_regs`

## Requirements
- R1: After reset the pointer is 0 with the component counter at red, the read mask is 0xFF, the blink mask, command and test registers are 0x00, and both `bus_rdata` and `rgb_out` are 0.
- R2: A write to port 0 (`bus_sel`=2'b00) loads the pointer and returns the component counter to red, even in the middle of an entry. A read of port 0 returns the pointer.
- R3: Each write to port 1 (`bus_sel`=2'b01) stores the byte in the current component of the entry at the pointer, in the order red, green, blue. After blue, the pointer increments and wraps from 255 to 0.
- R4: Each read of port 1 returns the current component of the entry at the pointer and advances the counter exactly as a write does.
- R5: Port 2 (`bus_sel`=2'b10) accesses the control register whose number is the pointer: 4 is the read mask, 5 the blink mask, 6 the command, 7 the test register. Writes to any other number change nothing, and reads of them return 0, as do reads of port 3.
- R6: Write data is taken from byte lane `LANE` (default 0, bits 7:0) and the other lanes are ignored. Every read returns its byte copied into all four lanes. Read data appears one clock after the read cycle.
- R7: `rgb_out` one clock after an index is presented equals the entry at (index AND read mask), with red in bits 23:16, green in 15:8 and blue in 7:0.
- R8: While `blink_phase` is high, the bits set in the blink mask are also cleared from the index before the lookup. While it is low, the blink mask has no effect.
- R9: When command bit 6 (palette enable) is 0, `rgb_out` is 0 one clock later, whatever the index.
- R10: A palette write and a lookup of the same entry in the same cycle give the old value on `rgb_out`. The new value appears from the following lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Host access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Port: 0 address, 1 colour-map data, 2 control data, 3 reserved |
| bus_wdata | input | 32 | Write data; lane `LANE` used |
| bus_rdata | output | 32 | Read data, byte copied into every lane |
| pix_idx | input | 8 | Pixel index for lookup |
| blink_phase | input | 1 | High during the blink-off phase |
| rgb_out | output | 24 | Looked-up colour {R,G,B} |

## Verification
The assertions check the pointer and component sequencing on every cycle. This covers the counter never reaching an illegal value, an address load restarting at red, the 255-to-0 wrap, and the pointer holding when no access occurs. They also check that unmapped control writes leave every mask untouched and that a disabled palette yields black. Which byte sits in which entry, the masking arithmetic, lane selection and the old-value result on a write/lookup collision depend on stored data. Only the bench can show these, by loading the full table and sweeping all 256 indices under several mask and blink settings.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR = 2'b00,
    PORT_PAL  = 2'b01,
    PORT_CTRL = 2'b10,
    PORT_RSVD = 2'b11
  } port_e;

  localparam int NCOMP = 3;
  localparam logic [1:0] COMP_R = 2'd0;
  localparam logic [1:0] COMP_B = 2'd2;

  localparam int IX_RMASK = 4;
  localparam int IX_BMASK = 5;
  localparam int IX_CMD   = 6;
  localparam int IX_TEST  = 7;

  localparam int CMD_PAL_EN_BIT = 6;
endpackage

// File: rtl/pdac_seq.sv
module pdac_seq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic [1:0]        comp
);
  import pdac_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      comp <= COMP_R;
    end else if (addr_wr) begin
      ptr  <= addr_val;
      comp <= COMP_R;
    end else if (step) begin
      if (comp == COMP_B) begin
        comp <= COMP_R;
        ptr  <= ptr + 1'b1;
      end else begin
        comp <= comp + 2'd1;
      end
    end
  end

  p_comp_legal_r3: assert property (@(posedge clk) disable iff (rst)
    comp != 2'd3);

  p_addr_load_r2: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> (ptr == $past(addr_val)) && (comp == COMP_R));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !addr_wr && comp == COMP_B && ptr == '1) |=> (ptr == '0) && (comp == COMP_R));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!step && !addr_wr) |=> $stable(ptr) && $stable(comp));
endmodule

// File: rtl/pdac_ctrl.sv
module pdac_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rmask,
  output logic [DATA_W-1:0] bmask,
  output logic              pal_en
);
  import pdac_pkg::*;

  logic [DATA_W-1:0] cmd_q, test_q;
  logic mapped;

  assign mapped = (idx == ADDR_W'(IX_RMASK)) || (idx == ADDR_W'(IX_BMASK)) ||
                  (idx == ADDR_W'(IX_CMD))   || (idx == ADDR_W'(IX_TEST));

  always_ff @(posedge clk) begin
    if (rst) begin
      rmask  <= '1;
      bmask  <= '0;
      cmd_q  <= '0;
      test_q <= '0;
    end else if (wr_en) begin
      if (idx == ADDR_W'(IX_RMASK)) rmask  <= wdata;
      if (idx == ADDR_W'(IX_BMASK)) bmask  <= wdata;
      if (idx == ADDR_W'(IX_CMD))   cmd_q  <= wdata;
      if (idx == ADDR_W'(IX_TEST))  test_q <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (idx == ADDR_W'(IX_RMASK)) rd_data = rmask;
    if (idx == ADDR_W'(IX_BMASK)) rd_data = bmask;
    if (idx == ADDR_W'(IX_CMD))   rd_data = cmd_q;
    if (idx == ADDR_W'(IX_TEST))  rd_data = test_q;
  end

  assign pal_en = cmd_q[CMD_PAL_EN_BIT];

  p_unmapped_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped) |=> $stable(rmask) && $stable(bmask) && $stable(cmd_q) && $stable(test_q));
endmodule

// File: rtl/pdac_bank.sv
module pdac_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hre,
  input  logic [ADDR_W-1:0] haddr,
  output logic [DATA_W-1:0] hq,
  input  logic [ADDR_W-1:0] laddr,
  output logic [DATA_W-1:0] lq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)      hq <= '0;
    else if (hre) hq <= mem[haddr];
  end

  always_ff @(posedge clk) begin
    if (rst) lq <= '0;
    else     lq <= mem[laddr];
  end
endmodule

// File: rtl/pdac_regs.sv
module pdac_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  parameter int LANE   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_cs,
  input  logic                  bus_we,
  input  logic [1:0]            bus_sel,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [ADDR_W-1:0]     pix_idx,
  input  logic                  blink_phase,
  output logic [3*DATA_W-1:0]   rgb_out
);
  import pdac_pkg::*;

  localparam int LANES = BUS_W / DATA_W;

  port_e              port;
  logic [DATA_W-1:0]  wbyte;
  logic               unused_lanes;
  logic               addr_wr, step, pal_we, ctrl_we, rd_cyc;
  logic [ADDR_W-1:0]  ptr;
  logic [1:0]         comp;
  logic [DATA_W-1:0]  ctrl_rd, rmask, bmask;
  logic               pal_en;
  logic [DATA_W-1:0]  hq [NCOMP];
  logic [DATA_W-1:0]  lq [NCOMP];
  logic [ADDR_W-1:0]  eff_idx;
  logic               rd_pal_q, en_q;
  logic [1:0]         rd_comp_q;
  logic [DATA_W-1:0]  hold_q, rd_byte;

  assign port         = port_e'(bus_sel);
  assign wbyte        = bus_wdata[LANE*DATA_W +: DATA_W];
  assign unused_lanes = ^bus_wdata;

  assign addr_wr = bus_cs && bus_we && (port == PORT_ADDR);
  assign step    = bus_cs && (port == PORT_PAL);
  assign pal_we  = step && bus_we;
  assign ctrl_we = bus_cs && bus_we && (port == PORT_CTRL);
  assign rd_cyc  = bus_cs && !bus_we;

  pdac_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .addr_val(ADDR_W'(wbyte)),
    .step(step), .ptr(ptr), .comp(comp)
  );

  pdac_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_we), .idx(ptr), .wdata(wbyte),
    .rd_data(ctrl_rd), .rmask(rmask), .bmask(bmask), .pal_en(pal_en)
  );

  always_comb begin
    eff_idx = pix_idx & ADDR_W'(rmask);
    if (blink_phase) eff_idx = eff_idx & ~ADDR_W'(bmask);
  end

  for (genvar k = 0; k < NCOMP; k++) begin : g_bank
    pdac_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst(rst),
      .we(pal_we && (comp == 2'(k))), .waddr(ptr), .wdata(wbyte),
      .hre(rd_cyc && (port == PORT_PAL) && (comp == 2'(k))), .haddr(ptr), .hq(hq[k]),
      .laddr(eff_idx), .lq(lq[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pal_q  <= 1'b0;
      rd_comp_q <= COMP_R;
      hold_q    <= '0;
      en_q      <= 1'b0;
    end else begin
      en_q <= pal_en;
      if (rd_cyc) begin
        rd_pal_q  <= (port == PORT_PAL);
        rd_comp_q <= comp;
        case (port)
          PORT_ADDR: hold_q <= DATA_W'(ptr);
          PORT_CTRL: hold_q <= ctrl_rd;
          default:   hold_q <= '0;
        endcase
      end
    end
  end

  always_comb begin
    rd_byte = hold_q;
    if (rd_pal_q) begin
      case (rd_comp_q)
        2'd0:    rd_byte = hq[0];
        2'd1:    rd_byte = hq[1];
        default: rd_byte = hq[2];
      endcase
    end
  end

  assign bus_rdata = {LANES{rd_byte}};
  assign rgb_out   = en_q ? {lq[0], lq[1], lq[2]} : '0;

  p_blank_r9: assert property (@(posedge clk) disable iff (rst)
    !pal_en |=> (rgb_out == '0));
endmodule

// File: tb/pdac_regs_tb.sv
module pdac_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_sel = 2'b00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic        blink_phase = 1'b0;
  logic [23:0] rgb_out;

  int checks = 0;
  int failures = 0;
  logic [7:0] pal [256][3];

  always #5 clk = ~clk;

  pdac_regs u_dut (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx),
    .blink_phase(blink_phase), .rgb_out(rgb_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_sel = sel; bus_wdata = data;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wrb(input logic [1:0] sel, input logic [7:0] b);
    wr(sel, {4{b}});
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] data);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_sel = sel;
    @(negedge clk);
    data = bus_rdata;
    bus_cs = 1'b0;
  endtask

  task automatic look(input logic [7:0] idx, input logic bl, output logic [23:0] v);
    @(negedge clk);
    pix_idx = idx; blink_phase = bl;
    @(negedge clk);
    v = rgb_out;
  endtask

  task automatic ctrl_set(input logic [7:0] ix, input logic [7:0] v);
    wrb(2'b00, ix);
    wrb(2'b10, v);
  endtask

  function automatic logic [23:0] ent(input int i);
    return {pal[i][0], pal[i][1], pal[i][2]};
  endfunction

  task automatic sweep(input string req, input logic [7:0] rm, input logic [7:0] bm, input logic bl);
    logic [23:0] v;
    for (int i = 0; i < 256; i++) begin
      int e;
      e = i & rm;
      if (bl) e = e & ~bm;
      look(8'(i), bl, v);
      chk(req, {8'h0, v}, {8'h0, ent(e)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [23:0] v;
    logic [7:0] oldg, oldb;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 rgb", {8'h0, rgb_out}, 32'h0);
    rd(2'b00, r); chk("R1 addr", r, 32'h0);
    wrb(2'b00, 8'd4); rd(2'b10, r); chk("R1 rmask", r, 32'hFFFFFFFF);
    wrb(2'b00, 8'd5); rd(2'b10, r); chk("R1 bmask", r, 32'h0);
    wrb(2'b00, 8'd6); rd(2'b10, r); chk("R1 cmd", r, 32'h0);
    wrb(2'b00, 8'd7); rd(2'b10, r); chk("R1 test", r, 32'h0);

    // R5 / R6 control registers and lanes
    ctrl_set(8'd6, 8'h43); rd(2'b10, r); chk("R5 cmd", r, 32'h43434343);
    wrb(2'b00, 8'd7); wr(2'b10, 32'hAABBCC5A); rd(2'b10, r); chk("R6 lane select", r, 32'h5A5A5A5A);
    wrb(2'b00, 8'd2); wrb(2'b10, 8'h77); rd(2'b10, r); chk("R5 unmapped read", r, 32'h0);
    wrb(2'b00, 8'd4); rd(2'b10, r); chk("R5 rmask untouched", r, 32'hFFFFFFFF);
    rd(2'b11, r); chk("R5 reserved read", r, 32'h0);
    wr(2'b00, 32'h112233C8); rd(2'b00, r); chk("R2 addr read lane", r, 32'hC8C8C8C8);

    // R3 full load
    wrb(2'b00, 8'd0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        pal[i][c] = 8'((i * 37) + (c * 101) + 11);
        wrb(2'b01, pal[i][c]);
      end
    rd(2'b00, r); chk("R3 pointer wrapped", r, 32'h0);

    // R4 full readback
    wrb(2'b00, 8'd0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        rd(2'b01, r);
        chk("R4 readback", r, {4{pal[i][c]}});
      end

    // R2 address rewrite restarts at red
    wrb(2'b00, 8'd10); wrb(2'b01, 8'hE1); wrb(2'b01, 8'hE2);
    pal[10][0] = 8'hE1; pal[10][1] = 8'hE2;
    wrb(2'b00, 8'd10); rd(2'b01, r); chk("R2 restart red", r, 32'hE1E1E1E1);
    rd(2'b01, r); chk("R2 then green", r, 32'hE2E2E2E2);
    wrb(2'b00, 8'd10); wrb(2'b01, 8'hD0); pal[10][0] = 8'hD0;
    wrb(2'b00, 8'd10); rd(2'b01, r); chk("R2 write after reload", r, 32'hD0D0D0D0);

    // R3 wrap 255 -> 0
    wrb(2'b00, 8'd255);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b;
      b = 8'(8'h90 + k);
      if (k < 3) pal[255][k] = b; else pal[0][k-3] = b;
      wrb(2'b01, b);
    end
    wrb(2'b00, 8'd255);
    for (int k = 0; k < 6; k++) begin
      rd(2'b01, r);
      chk("R3 wrap", r, {4{8'(8'h90 + k)}});
    end

    // R7 / R8 lookups
    sweep("R7 full mask", 8'hFF, 8'h00, 1'b0);
    ctrl_set(8'd4, 8'h0F);
    sweep("R7 read mask 0F", 8'h0F, 8'h00, 1'b0);
    ctrl_set(8'd4, 8'hFF); ctrl_set(8'd5, 8'hF0);
    sweep("R8 blink on", 8'hFF, 8'hF0, 1'b1);
    sweep("R8 blink off", 8'hFF, 8'hF0, 1'b0);
    ctrl_set(8'd4, 8'h3C); ctrl_set(8'd5, 8'h0C);
    sweep("R8 both masks", 8'h3C, 8'h0C, 1'b1);
    ctrl_set(8'd4, 8'hFF); ctrl_set(8'd5, 8'h00);

    // R9 palette disabled
    ctrl_set(8'd6, 8'h03);
    for (int i = 1; i < 256; i += 51) begin
      look(8'(i), 1'b0, v);
      chk("R9 blank", {8'h0, v}, 32'h0);
    end
    ctrl_set(8'd6, 8'h43);
    look(8'd1, 1'b0, v); chk("R9 re-enabled", {8'h0, v}, {8'h0, ent(1)});

    // R10 collision
    wrb(2'b00, 8'd5);
    oldg = pal[5][1]; oldb = pal[5][2];
    @(negedge clk);
    pix_idx = 8'd5; blink_phase = 1'b0;
    bus_cs = 1'b1; bus_we = 1'b1; bus_sel = 2'b01; bus_wdata = {4{8'h3E}};
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
    chk("R10 old value", {8'h0, rgb_out}, {8'h0, ent(5)});
    @(negedge clk);
    chk("R10 new value", {8'h0, rgb_out}, {8'h0, 8'h3E, oldg, oldb});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule